// File: doc/BRIEF.md
# Reset and Boot-Fetch Sequencer

This block is the reset-exit front end of a small processor that uses segmented addressing. A raw reset line enters through a synchronizer. A reset takes effect only after the synchronized level has stayed high for a minimum number of clocks. A valid reset seeds the architectural registers with their power-up values. When the reset line drops, the block requests the first instruction fetch. The fetch address is 20 bits wide: the 16-bit code segment shifted left by four, plus the 16-bit instruction pointer.

Both data paths use valid/ready handshakes. The fetch request holds its address until the consumer accepts it. After that the block waits for a far-jump target on the jump channel. That target replaces the code segment and the instruction pointer together, and the next fetch request is raised at the new combined address. Decode, execution and memory are outside this block.

Back-pressure rules are as follows. `fetch_valid_o` stays high and `fetch_addr_o` stays unchanged until a clock edge on which `fetch_ready_i` is high. `jump_ready_o` is high only while the block is idle, meaning the last fetch has been accepted and no reset is in effect. A jump offered while `jump_ready_o` is low is not taken.

Top module: `boot_fetch_seq`

## Requirements
- R1: A reset is valid only if `rst_raw_i` is sampled high on at least 4 consecutive rising edges. A shorter pulse is ignored: the registers, the fetch request and the jump readiness all keep their values.
- R2: A valid reset loads the code segment with FFFFh and the instruction pointer with 0000h.
- R3: A valid reset loads the data, extra and stack segments and the stack pointer with 0000h.
- R4: A valid reset loads the flags word with 0000h, which clears the interrupt-enable flag at bit 9.
- R5: The fetch address is (segment × 16 + offset) modulo 2^20. For example, FFFFh:0010h gives 00000h and 1234h:5678h gives 179B8h.
- R6: The first fetch after reset goes to FFFF0h.
- R7: `fetch_valid_o` stays low while a valid reset is in effect. It rises after the third rising edge that follows the drop of `rst_raw_i`.
- R8: While `fetch_valid_o` is high and `fetch_ready_i` is low, the request and its address hold steady. After an accepting edge, `fetch_valid_o` falls.
- R9: `jump_ready_o` rises after a fetch is accepted. An accepted jump loads the segment and the offset together, and the next fetch goes to the new address. For example, F000h:E05Bh gives FE05Bh.
- R10: A jump offered while `jump_ready_o` is low changes neither the code segment nor the instruction pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_raw_i | input | 1 | Raw reset level, active high, asynchronous to clk |
| jump_valid_i | input | 1 | Far-jump target offered |
| jump_ready_o | output | 1 | Block idle and able to take a jump |
| jump_seg_i | input | 16 | Jump target segment |
| jump_off_i | input | 16 | Jump target offset |
| fetch_valid_o | output | 1 | Fetch request |
| fetch_ready_i | input | 1 | Fetch consumer accepts |
| fetch_addr_o | output | 20 | Physical fetch address |
| cs_o | output | 16 | Code segment |
| ip_o | output | 16 | Instruction pointer |
| ds_o | output | 16 | Data segment |
| es_o | output | 16 | Extra segment |
| ss_o | output | 16 | Stack segment |
| sp_o | output | 16 | Stack pointer |
| flags_o | output | 16 | Flags word |

## Verification
The reset filter is driven with a long pulse, a pulse of exactly 4 clocks and a pulse of 3 clocks. These separate a correct threshold from one that is off by one in either direction. The 3-clock pulse is applied while the registers hold a non-reset jump target, so a filter that leaks would show up on `cs_o`.

The address adder is tried with several targets:
- the reset value, FFFF0h;
- a mid-range jump, F000h:E05Bh;
- a jump whose carries ripple through, 1234h:5678h;
- a jump that overflows 20 bits, FFFFh:0010h.

Together these catch a wrong shift amount, a missing add and a missing wrap. Stalling `fetch_ready_i` while offering a jump checks that the address holds and that a jump outside the idle window is refused.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned PADDR_W   = 20;
  localparam int unsigned SEG_SHIFT = 4;
  localparam int unsigned IE_BIT    = 9;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [PADDR_W-1:0] paddr_t;

  typedef struct packed {
    word_t cs;
    word_t ip;
    word_t ds;
    word_t es;
    word_t ss;
    word_t sp;
    word_t flags;
  } arch_regs_t;

  typedef enum logic [1:0] {
    ST_HELD  = 2'd0,
    ST_FETCH = 2'd1,
    ST_IDLE  = 2'd2
  } seq_state_e;

  localparam arch_regs_t BOOT_REGS = '{
    cs:    16'hFFFF,
    ip:    16'h0000,
    ds:    16'h0000,
    es:    16'h0000,
    ss:    16'h0000,
    sp:    16'h0000,
    flags: 16'h0000
  };
endpackage

// File: rtl/boot_rst_filter.sv
module boot_rst_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_CLKS    = 4
) (
  input  logic clk,
  input  logic rst_raw_i,
  output logic rst_sync_o,
  output logic rst_arm_o
);
  localparam int unsigned CNT_W = $clog2(MIN_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_CLKS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       hi_cnt_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) sync_q[g] <= rst_raw_i;
    end else begin : g_next
      always_ff @(posedge clk) sync_q[g] <= sync_q[g-1];
    end
  end

  assign rst_sync_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_sync_o)
      hi_cnt_q <= '0;
    else if (hi_cnt_q != CNT_TOP)
      hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assign rst_arm_o = rst_sync_o && (hi_cnt_q == CNT_TOP);

  // R1: a low synchronized level always clears the qualification
  a_r1_low_clears: assert property (@(posedge clk)
    !rst_sync_o |=> !rst_arm_o);

  // R1: qualification needs the level to have been high on the previous cycle too
  a_r1_needs_history: assert property (@(posedge clk) disable iff (!rst_sync_o)
    rst_arm_o |-> $past(rst_sync_o));
endmodule

// File: rtl/boot_addr_gen.sv
module boot_addr_gen #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] seg_base;
  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    seg_base = ADDR_W'(seg_i) << SHIFT;
    off_ext  = ADDR_W'(off_i);
    addr_o   = seg_base + off_ext;
  end
endmodule

// File: rtl/boot_arch_regs.sv
module boot_arch_regs
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync_i,
  input  logic       rst_arm_i,
  input  logic       jump_fire_i,
  input  word_t      jump_seg_i,
  input  word_t      jump_off_i,
  output arch_regs_t regs_o
);
  arch_regs_t regs_q;

  always_ff @(posedge clk) begin
    if (rst_arm_i) begin
      regs_q <= BOOT_REGS;
    end else if (jump_fire_i) begin
      regs_q.cs <= jump_seg_i;
      regs_q.ip <= jump_off_i;
    end
  end

  assign regs_o = regs_q;

  a_r2_code_seed: assert property (@(posedge clk) disable iff (!rst_sync_i)
    rst_arm_i |=> (regs_o.cs == 16'hFFFF) && (regs_o.ip == 16'h0000));

  a_r3_data_seed: assert property (@(posedge clk) disable iff (!rst_sync_i)
    rst_arm_i |=> (regs_o.ds == '0) && (regs_o.es == '0) &&
                  (regs_o.ss == '0) && (regs_o.sp == '0));

  a_r4_flags_seed: assert property (@(posedge clk) disable iff (!rst_sync_i)
    rst_arm_i |=> !regs_o.flags[IE_BIT] && (regs_o.flags == '0));

  a_r9_jump_loads: assert property (@(posedge clk) disable iff (rst_sync_i)
    jump_fire_i |=> (regs_o.cs == $past(jump_seg_i)) && (regs_o.ip == $past(jump_off_i)));
endmodule

// File: rtl/boot_fetch_seq.sv
module boot_fetch_seq
  import boot_pkg::*;
#(
  parameter int unsigned MIN_RST_CLKS = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_raw_i,
  input  logic        jump_valid_i,
  output logic        jump_ready_o,
  input  logic [15:0] jump_seg_i,
  input  logic [15:0] jump_off_i,
  output logic        fetch_valid_o,
  input  logic        fetch_ready_i,
  output logic [19:0] fetch_addr_o,
  output logic [15:0] cs_o,
  output logic [15:0] ip_o,
  output logic [15:0] ds_o,
  output logic [15:0] es_o,
  output logic [15:0] ss_o,
  output logic [15:0] sp_o,
  output logic [15:0] flags_o
);
  logic       rst_sync;
  logic       rst_arm;
  logic       jump_fire;
  arch_regs_t regs;
  seq_state_e state_q;
  seq_state_e state_d;

  boot_rst_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_CLKS   (MIN_RST_CLKS)
  ) i_filter (
    .clk       (clk),
    .rst_raw_i (rst_raw_i),
    .rst_sync_o(rst_sync),
    .rst_arm_o (rst_arm)
  );

  boot_arch_regs i_regs (
    .clk        (clk),
    .rst_sync_i (rst_sync),
    .rst_arm_i  (rst_arm),
    .jump_fire_i(jump_fire),
    .jump_seg_i (jump_seg_i),
    .jump_off_i (jump_off_i),
    .regs_o     (regs)
  );

  boot_addr_gen #(
    .SEG_W (WORD_W),
    .OFF_W (WORD_W),
    .SHIFT (SEG_SHIFT),
    .ADDR_W(PADDR_W)
  ) i_addr (
    .seg_i (regs.cs),
    .off_i (regs.ip),
    .addr_o(fetch_addr_o)
  );

  assign jump_ready_o  = (state_q == ST_IDLE);
  assign fetch_valid_o = (state_q == ST_FETCH);
  assign jump_fire     = jump_valid_i && jump_ready_o && !rst_arm;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HELD:  if (!rst_sync) state_d = ST_FETCH;
      ST_FETCH: if (fetch_ready_i) state_d = ST_IDLE;
      ST_IDLE:  if (jump_fire) state_d = ST_FETCH;
      default:  state_d = ST_HELD;
    endcase
    if (rst_arm) state_d = ST_HELD;
  end

  always_ff @(posedge clk) state_q <= state_d;

  assign cs_o    = regs.cs;
  assign ip_o    = regs.ip;
  assign ds_o    = regs.ds;
  assign es_o    = regs.es;
  assign ss_o    = regs.ss;
  assign sp_o    = regs.sp;
  assign flags_o = regs.flags;

  a_r7_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_sync)
    rst_arm |=> !fetch_valid_o);

  a_r7_release_fetch: assert property (@(posedge clk) disable iff (rst_sync)
    (state_q == ST_HELD) |=> fetch_valid_o);

  a_r8_hold_request: assert property (@(posedge clk) disable iff (rst_sync)
    fetch_valid_o && !fetch_ready_i |=> fetch_valid_o && $stable(fetch_addr_o));

  a_r10_refused_jump: assert property (@(posedge clk) disable iff (rst_sync)
    jump_valid_i && !jump_ready_o |=> (cs_o == $past(cs_o)) && (ip_o == $past(ip_o)));
endmodule

// File: tb/test_boot_fetch_seq.sv
module test_boot_fetch_seq;
  logic        clk = 1'b0;
  logic        rst_raw = 1'b1;
  logic        jump_valid = 1'b0;
  logic        jump_ready;
  logic [15:0] jump_seg = '0;
  logic [15:0] jump_off = '0;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [19:0] fetch_addr;
  logic [15:0] cs, ip, ds, es, ss, sp, flags;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  boot_fetch_seq i_boot_fetch_seq (
    .clk          (clk),
    .rst_raw_i    (rst_raw),
    .jump_valid_i (jump_valid),
    .jump_ready_o (jump_ready),
    .jump_seg_i   (jump_seg),
    .jump_off_i   (jump_off),
    .fetch_valid_o(fetch_valid),
    .fetch_ready_i(fetch_ready),
    .fetch_addr_o (fetch_addr),
    .cs_o         (cs),
    .ip_o         (ip),
    .ds_o         (ds),
    .es_o         (es),
    .ss_o         (ss),
    .sp_o         (sp),
    .flags_o      (flags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_reset(input int n);
    @(negedge clk);
    rst_raw = 1'b1;
    cycles(n);
    rst_raw = 1'b0;
  endtask

  task automatic accept_fetch();
    fetch_ready = 1'b1;
    cycles(1);
    fetch_ready = 1'b0;
  endtask

  task automatic do_jump(input logic [15:0] s, input logic [15:0] o);
    jump_seg = s;
    jump_off = o;
    jump_valid = 1'b1;
    cycles(1);
    jump_valid = 1'b0;
  endtask

  task automatic t_long_reset();
    cycles(10);
    check("R2 cs seed", cs, 32'hFFFF);
    check("R2 ip seed", ip, 32'h0);
    check("R3 ds/es seed", {ds, es}, 32'h0);
    check("R3 ss/sp seed", {ss, sp}, 32'h0);
    check("R4 flags seed", flags, 32'h0);
    check("R4 interrupt enable clear", flags[9], 32'h0);
    check("R7 no fetch in reset", fetch_valid, 32'h0);
    rst_raw = 1'b0;
    cycles(2);
    check("R7 still quiet after two edges", fetch_valid, 32'h0);
    cycles(1);
    check("R7 fetch on third edge", fetch_valid, 32'h1);
    check("R6 first address", fetch_addr, 32'hFFFF0);
  endtask

  task automatic t_backpressure();
    jump_seg = 16'hAAAA;
    jump_off = 16'h5555;
    jump_valid = 1'b1;
    cycles(3);
    jump_valid = 1'b0;
    check("R8 request held", fetch_valid, 32'h1);
    check("R8 address held", fetch_addr, 32'hFFFF0);
    check("R9 no jump ready while fetching", jump_ready, 32'h0);
    check("R10 refused jump cs", cs, 32'hFFFF);
    check("R10 refused jump ip", ip, 32'h0);
    accept_fetch();
    check("R8 request drops", fetch_valid, 32'h0);
    check("R9 jump ready after accept", jump_ready, 32'h1);
  endtask

  task automatic t_jump(input logic [15:0] s, input logic [15:0] o,
                        input logic [19:0] exp, input string tag);
    do_jump(s, o);
    check({tag, " request"}, fetch_valid, 32'h1);
    check({tag, " address"}, fetch_addr, {12'h0, exp});
    check({tag, " cs/ip"}, {cs, ip}, {s, o});
    accept_fetch();
  endtask

  task automatic t_short_reset();
    pulse_reset(3);
    cycles(8);
    check("R1 short pulse keeps cs", cs, 32'h1234);
    check("R1 short pulse keeps ip", ip, 32'h5678);
    check("R1 short pulse keeps idle", jump_ready, 32'h1);
    check("R1 short pulse no fetch", fetch_valid, 32'h0);
    pulse_reset(4);
    cycles(8);
    check("R1 four clocks resets cs", cs, 32'hFFFF);
    check("R1 four clocks resets ip", ip, 32'h0);
    check("R7 fetch after valid reset", fetch_valid, 32'h1);
    check("R6 address after second reset", fetch_addr, 32'hFFFF0);
  endtask

  initial begin
    t_long_reset();
    t_backpressure();
    t_jump(16'hF000, 16'hE05B, 20'hFE05B, "R9 far jump");
    t_jump(16'hFFFF, 16'h0010, 20'h00000, "R5 wrap");
    t_jump(16'h1234, 16'h5678, 20'h179B8, "R5 carry");
    t_short_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule